// File: doc/BRIEF.md
# Chip-Enable-Timed Flash Write Sequencer

This block is a bus master that performs write cycles on a parallel NOR-style flash device. The write pulse is formed by the two card-enable strobes, which are always driven together. Write-enable goes low before the enables fall and is released only after they have risen. The address is therefore sampled by the flash when the enables fall, and the data when they rise.

A host hands over one request at a time through a valid/ready pair: an address, a data byte and a mode bit. In raw mode a single write cycle is issued. In program mode three fixed unlock/command writes taken from a parameter table come first, and the user address and data form the fourth write. Every setup, hold, width and cycle time is turned into a clock count with a ceiling division by the clock period, with a minimum of one cycle. The phase lengths are therefore correct for any clock period the parameters describe. Output enable stays high throughout, and the block stays busy until the recovery time after the last write has elapsed.

Top module: `cewr_seq`

## Requirements
- R1: After reset, ce1_n, ce2_n, we_n and oe_n are 1, req_ready is 1 and busy is 0.
- R2: A request accepted with req_prog=0 produces exactly one enable pulse. The flash sees the request address on the falling edge and the request data on the rising edge.
- R3: A request accepted with req_prog=1 produces four enable pulses in this order: (0x0555, 0xAA), (0x02AA, 0x55), (0x0555, 0xA0), then the request address and data.
- R4: Each enable pulse is low for at least ceil(50 ns / period) cycles. Data is unchanged while the enables are low and has been stable for at least ceil(50 ns / period) cycles when they rise.
- R5: Between two pulses the enables stay high for at least ceil(20 ns / period) cycles.
- R6: The address is stable for at least ceil(10 ns / period) cycles before the enables fall. It does not change while they are low and has been held at least ceil(50 ns / period) cycles when they rise.
- R7: we_n is low in the cycle before the enables fall and still low in the cycle they rise. It never changes while the enables are low.
- R8: After a write, the address does not change again until at least ceil(150 ns / period) cycles after its previous change.
- R9: ce1_n and ce2_n are equal in every cycle.
- R10: oe_n stays high, and busy is always the inverse of req_ready. busy falls no earlier than ceil(20 ns / period) and ceil(10 ns / period) cycles after the last enable rise, and no earlier than ceil(150 ns / period) cycles after the last address change.
- R11: A request presented while req_ready is 0 is ignored and produces no enable pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request strobe |
| req_prog | input | 1 | 1 = four-write program sequence, 0 = one raw write |
| req_addr | input | ADDR_W | Target address |
| req_data | input | DATA_W | Data byte |
| req_ready | output | 1 | Request is taken on a cycle with req_valid and req_ready both high |
| busy | output | 1 | A sequence is in progress |
| flash_addr | output | ADDR_W | Flash address bus |
| flash_dq | output | DATA_W | Flash data bus (write direction) |
| ce1_n | output | 1 | Card enable 1, active low |
| ce2_n | output | 1 | Card enable 2, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low (held high) |

## Verification
Two functions can meet in one cycle: the end of the recovery gap of one sequence and the acceptance of the next request. The bench provokes this by keeping req_valid high with a new request while the previous one is still running, so the request is taken on the first idle cycle. This case is judged at the pins. The address-change-to-address-change distance across the boundary must still reach the write cycle time, the enables must stay high for their minimum, and the scoreboard must see the new sequence's pairs in order right after the old ones.

// File: rtl/cewr_pkg.sv
package cewr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_PULSE,
    PH_HOLD,
    PH_GAP
  } phase_e;

  // minimum time in ns -> whole clock cycles, never below one
  function automatic int ns_to_cyc(input int t_ns, input int per_ns);
    int c;
    c = (t_ns + per_ns - 1) / per_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // recovery gap after the hold cycle: covers enable-high time, full
  // write cycle time and the output-enable hold after the last write
  function automatic int gap_len(input int n_as, input int n_pulse, input int n_hold,
                                 input int n_cph, input int n_wc, input int n_oeh);
    int g;
    g = max2(n_cph - n_hold - n_as, n_wc - n_as - n_pulse - n_hold);
    g = max2(g, n_oeh - n_hold);
    g = max2(g, 1);
    return g;
  endfunction

endpackage

// File: rtl/cewr_phase_timer.sv
module cewr_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/cewr_beat_src.sv
module cewr_beat_src #(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 8,
  parameter int                BEAT_W    = 2,
  parameter logic [ADDR_W-1:0] CMD0_ADDR = '0,
  parameter logic [ADDR_W-1:0] CMD1_ADDR = '0,
  parameter logic [ADDR_W-1:0] CMD2_ADDR = '0,
  parameter logic [DATA_W-1:0] CMD0_DATA = '0,
  parameter logic [DATA_W-1:0] CMD1_DATA = '0,
  parameter logic [DATA_W-1:0] CMD2_DATA = '0
) (
  input  logic [BEAT_W-1:0] beat,
  input  logic              prog,
  input  logic [ADDR_W-1:0] usr_addr,
  input  logic [DATA_W-1:0] usr_data,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);

  // program mode: three table writes, then the user pair
  always_comb begin
    addr = usr_addr;
    data = usr_data;
    if (prog) begin
      case (beat)
        BEAT_W'(0): begin addr = CMD0_ADDR; data = CMD0_DATA; end
        BEAT_W'(1): begin addr = CMD1_ADDR; data = CMD1_DATA; end
        BEAT_W'(2): begin addr = CMD2_ADDR; data = CMD2_DATA; end
        default:    begin addr = usr_addr;  data = usr_data;  end
      endcase
    end
  end

endmodule

// File: rtl/cewr_seq.sv
module cewr_seq
  import cewr_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int T_WC_NS       = 150,
  parameter int T_AS_NS       = 10,
  parameter int T_AH_NS       = 50,
  parameter int T_DS_NS       = 50,
  parameter int T_CP_NS       = 50,
  parameter int T_CPH_NS      = 20,
  parameter int T_OEH_NS      = 10,
  parameter logic [ADDR_W-1:0] CMD0_ADDR = ADDR_W'(12'h555),
  parameter logic [ADDR_W-1:0] CMD1_ADDR = ADDR_W'(12'h2AA),
  parameter logic [ADDR_W-1:0] CMD2_ADDR = ADDR_W'(12'h555),
  parameter logic [DATA_W-1:0] CMD0_DATA = DATA_W'(8'hAA),
  parameter logic [DATA_W-1:0] CMD1_DATA = DATA_W'(8'h55),
  parameter logic [DATA_W-1:0] CMD2_DATA = DATA_W'(8'hA0)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_prog,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              req_ready,
  output logic              busy,
  output logic [ADDR_W-1:0] flash_addr,
  output logic [DATA_W-1:0] flash_dq,
  output logic              ce1_n,
  output logic              ce2_n,
  output logic              we_n,
  output logic              oe_n
);

  localparam int NUM_BEATS = 4;
  localparam int BEAT_W    = $clog2(NUM_BEATS);
  localparam int N_AS      = ns_to_cyc(T_AS_NS, CLK_PERIOD_NS);
  localparam int N_CP      = ns_to_cyc(T_CP_NS, CLK_PERIOD_NS);
  localparam int N_DS      = ns_to_cyc(T_DS_NS, CLK_PERIOD_NS);
  localparam int N_AH      = ns_to_cyc(T_AH_NS, CLK_PERIOD_NS);
  localparam int N_CPH     = ns_to_cyc(T_CPH_NS, CLK_PERIOD_NS);
  localparam int N_WC      = ns_to_cyc(T_WC_NS, CLK_PERIOD_NS);
  localparam int N_OEH     = ns_to_cyc(T_OEH_NS, CLK_PERIOD_NS);
  localparam int N_PULSE   = max2(max2(N_CP, N_DS), N_AH);
  localparam int N_HOLD    = 1;
  localparam int N_GAP     = gap_len(N_AS, N_PULSE, N_HOLD, N_CPH, N_WC, N_OEH);
  localparam int N_MAX     = max2(max2(N_AS, N_PULSE), max2(N_HOLD, N_GAP));
  localparam int CNT_W     = max2($clog2(N_MAX + 1), 1);

  phase_e             st_q, st_d;
  logic [BEAT_W-1:0]  beat_q, beat_d;
  logic               prog_q;
  logic [ADDR_W-1:0]  usr_addr_q, src_addr;
  logic [DATA_W-1:0]  usr_data_q, src_data;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  dq_q;
  logic               ce_q, we_q, busy_q;
  logic               ph_zero, last_q, enter_setup;
  logic [CNT_W-1:0]   load_val;

  // named internal events for the checker
  logic accept_w;
  logic phase_end_w;

  assign accept_w    = (st_q == PH_IDLE) && req_valid;
  assign phase_end_w = (st_q != PH_IDLE) && ph_zero;
  assign last_q      = prog_q ? (beat_q == BEAT_W'(NUM_BEATS - 1)) : 1'b1;

  always_comb begin
    st_d   = st_q;
    beat_d = beat_q;
    unique case (st_q)
      PH_IDLE:  if (req_valid) begin st_d = PH_SETUP; beat_d = '0; end
      PH_SETUP: if (ph_zero) st_d = PH_PULSE;
      PH_PULSE: if (ph_zero) st_d = PH_HOLD;
      PH_HOLD:  if (ph_zero) st_d = PH_GAP;
      PH_GAP: begin
        if (ph_zero) begin
          if (last_q) st_d = PH_IDLE;
          else begin
            st_d   = PH_SETUP;
            beat_d = beat_q + 1'b1;
          end
        end
      end
      default: st_d = PH_IDLE;
    endcase
  end

  always_comb begin
    unique case (st_d)
      PH_SETUP: load_val = CNT_W'(N_AS - 1);
      PH_PULSE: load_val = CNT_W'(N_PULSE - 1);
      PH_HOLD:  load_val = CNT_W'(N_HOLD - 1);
      PH_GAP:   load_val = CNT_W'(N_GAP - 1);
      default:  load_val = '0;
    endcase
  end

  assign enter_setup = (st_d == PH_SETUP) && (st_q != PH_SETUP);

  cewr_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept_w || phase_end_w),
    .load_val (load_val),
    .zero     (ph_zero)
  );

  cewr_beat_src #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEAT_W(BEAT_W),
    .CMD0_ADDR(CMD0_ADDR), .CMD1_ADDR(CMD1_ADDR), .CMD2_ADDR(CMD2_ADDR),
    .CMD0_DATA(CMD0_DATA), .CMD1_DATA(CMD1_DATA), .CMD2_DATA(CMD2_DATA)
  ) u_src (
    .beat     (beat_d),
    .prog     (accept_w ? req_prog : prog_q),
    .usr_addr (accept_w ? req_addr : usr_addr_q),
    .usr_data (accept_w ? req_data : usr_data_q),
    .addr     (src_addr),
    .data     (src_data)
  );

  // all pin drivers are registered from the next phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= PH_IDLE;
      beat_q     <= '0;
      prog_q     <= 1'b0;
      usr_addr_q <= '0;
      usr_data_q <= '0;
      addr_q     <= '0;
      dq_q       <= '0;
      ce_q       <= 1'b1;
      we_q       <= 1'b1;
      busy_q     <= 1'b0;
    end else begin
      st_q   <= st_d;
      beat_q <= beat_d;
      if (accept_w) begin
        prog_q     <= req_prog;
        usr_addr_q <= req_addr;
        usr_data_q <= req_data;
      end
      if (enter_setup) begin
        addr_q <= src_addr;
        dq_q   <= src_data;
      end
      ce_q   <= (st_d != PH_PULSE);
      we_q   <= !((st_d == PH_SETUP) || (st_d == PH_PULSE) || (st_d == PH_HOLD));
      busy_q <= (st_d != PH_IDLE);
    end
  end

  assign req_ready  = (st_q == PH_IDLE);
  assign busy       = busy_q;
  assign flash_addr = addr_q;
  assign flash_dq   = dq_q;
  assign ce1_n      = ce_q;
  assign ce2_n      = ce_q;
  assign we_n       = we_q;
  assign oe_n       = 1'b1;

endmodule

// File: rtl/cewr_chk.sv
module cewr_chk
  import cewr_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int T_CP_NS       = 50,
  parameter int T_CPH_NS      = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce1_n,
  input logic              ce2_n,
  input logic              we_n,
  input logic              busy,
  input logic              accept_w,
  input logic [ADDR_W-1:0] flash_addr,
  input logic [DATA_W-1:0] flash_dq
);

  localparam int MIN_LO = ns_to_cyc(T_CP_NS, CLK_PERIOD_NS);
  localparam int MIN_HI = ns_to_cyc(T_CPH_NS, CLK_PERIOD_NS);

  logic [15:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= '1;
    end else begin
      if (ce1_n) begin
        lo_cnt <= '0;
        if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
      end else begin
        hi_cnt <= '0;
        if (lo_cnt != '1) lo_cnt <= lo_cnt + 1'b1;
      end
    end
  end

  // R9
  ce_pair_chk: assert property (@(posedge clk) disable iff (!rst_n) ce1_n == ce2_n);
  // R7
  we_setup_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(ce1_n) |-> $past(!we_n));
  // R7
  we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(ce1_n) |-> !we_n);
  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce1_n && $past(!ce1_n)) |-> $stable(flash_addr));
  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce1_n && $past(!ce1_n)) |-> $stable(flash_dq));
  // R4
  ce_low_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce1_n) |-> (32'(lo_cnt) >= MIN_LO));
  // R5
  ce_high_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ce1_n) |-> (32'(hi_cnt) >= MIN_HI));
  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) accept_w |=> busy);
  // R10
  pulse_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) !ce1_n |-> busy);

endmodule

bind cewr_seq cewr_chk #(
  .CLK_PERIOD_NS(CLK_PERIOD_NS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .T_CP_NS(T_CP_NS), .T_CPH_NS(T_CPH_NS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2_n(ce2_n), .we_n(we_n),
  .busy(busy), .accept_w(accept_w), .flash_addr(flash_addr), .flash_dq(flash_dq)
);

// File: tb/test_cewr_seq.sv
`timescale 1ns/1ps
module test_cewr_seq;

  localparam int PER = 10;

  function automatic int cdiv(input int t);
    int c;
    c = t / PER;
    if (c * PER < t) c = c + 1;
    if (c < 1) c = 1;
    return c;
  endfunction

  localparam int E_AS  = cdiv(10);
  localparam int E_AH  = cdiv(50);
  localparam int E_DS  = cdiv(50);
  localparam int E_CP  = cdiv(50);
  localparam int E_CPH = cdiv(20);
  localparam int E_WC  = cdiv(150);
  localparam int E_OEH = cdiv(10);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_prog = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_data = '0;
  logic req_ready, busy, ce1_n, ce2_n, we_n, oe_n;
  logic [15:0] flash_addr;
  logic [7:0]  flash_dq;

  always #(PER/2) clk = ~clk;

  cewr_seq #(.CLK_PERIOD_NS(PER)) i_cewr_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_prog(req_prog),
    .req_addr(req_addr), .req_data(req_data), .req_ready(req_ready), .busy(busy),
    .flash_addr(flash_addr), .flash_dq(flash_dq), .ce1_n(ce1_n), .ce2_n(ce2_n),
    .we_n(we_n), .oe_n(oe_n)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  typedef struct { logic [15:0] a; logic [7:0] d; string tag; } exp_t;
  exp_t sb_q[$];

  task automatic push(input logic [15:0] a, input logic [7:0] d, input string tag);
    exp_t e;
    e.a = a; e.d = d; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // driver: expectations first, then hold valid until taken
  task automatic send(input logic [15:0] a, input logic [7:0] d, input bit prog);
    bit rdy;
    if (prog) begin
      push(16'h0555, 8'hAA, "R3");
      push(16'h02AA, 8'h55, "R3");
      push(16'h0555, 8'hA0, "R3");
      push(a, d, "R3");
    end else push(a, d, "R2");
    req_addr = a; req_data = d; req_prog = prog; req_valid = 1'b1;
    forever begin
      rdy = req_ready;
      @(negedge clk);
      if (rdy) break;
    end
    req_valid = 1'b0;
  endtask

  // monitor: pin-level flash model and timing observer
  logic prev_ce = 1'b1, prev_we = 1'b1, prev_busy = 1'b0;
  logic [15:0] prev_addr = '0, fall_addr = '0;
  logic [7:0]  prev_dq = '0, fall_dq = '0;
  int addr_age = 0, dq_age = 0, hi_cnt = 1000, lo_cnt = 0, since_rise = 1000;
  bit wrote_since = 0, moved_low = 0;
  int pulses = 0, ce_mis = 0, oe_low = 0, rb_mis = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ce1_n !== ce2_n) ce_mis++;
      if (oe_n !== 1'b1) oe_low++;
      if (busy === req_ready) rb_mis++;
      if (flash_addr != prev_addr) begin
        if (wrote_since) chk(addr_age + 1 >= E_WC, "R8", "addr change spacing", addr_age + 1, E_WC);
        addr_age = 0; wrote_since = 0;
      end else addr_age++;
      if (flash_dq != prev_dq) dq_age = 0; else dq_age++;

      if (!ce1_n && prev_ce) begin
        chk(addr_age >= E_AS, "R6", "addr setup", addr_age, E_AS);
        chk(hi_cnt >= E_CPH, "R5", "enable high time", hi_cnt, E_CPH);
        chk(prev_we == 1'b0, "R7", "we low before fall", prev_we, 0);
        fall_addr = flash_addr; fall_dq = flash_dq; lo_cnt = 1; moved_low = 0;
      end else if (!ce1_n) begin
        lo_cnt++;
        if (we_n != prev_we || flash_dq != prev_dq || flash_addr != prev_addr) moved_low = 1;
      end else if (ce1_n && !prev_ce) begin
        pulses++;
        chk(lo_cnt >= E_CP, "R4", "enable low width", lo_cnt, E_CP);
        chk(dq_age >= E_DS, "R4", "data setup", dq_age, E_DS);
        chk(addr_age >= E_AH, "R6", "addr hold", addr_age, E_AH);
        chk(we_n == 1'b0, "R7", "we low at rise", we_n, 0);
        chk(!moved_low, "R7", "pins moved while enabled", moved_low, 0);
        if (sb_q.size() == 0) chk(0, "R11", "unexpected write", fall_addr, 0);
        else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(fall_addr == e.a, e.tag, "captured address", fall_addr, e.a);
          chk(flash_dq == e.d, e.tag, "captured data", flash_dq, e.d);
        end
        wrote_since = 1; hi_cnt = 1; since_rise = 0;
      end else begin
        if (hi_cnt < 1000) hi_cnt++;
        if (since_rise < 1000) since_rise++;
      end

      if (prev_busy && !busy) begin
        chk(since_rise >= E_CPH && since_rise >= E_OEH, "R10", "busy after last rise", since_rise, E_CPH);
        chk(addr_age >= E_WC, "R10", "busy after addr change", addr_age, E_WC);
      end
      prev_ce = ce1_n; prev_we = we_n; prev_busy = busy;
      prev_addr = flash_addr; prev_dq = flash_dq;
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd == 50000) begin
      chk(0, "watchdog", "run did not end", wd, 0);
      finish_run();
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ce1_n == 1'b1 && ce2_n == 1'b1, "R1", "enables after reset", {ce1_n, ce2_n}, 3);
    chk(we_n == 1'b1, "R1", "we after reset", we_n, 1);
    chk(oe_n == 1'b1, "R1", "oe after reset", oe_n, 1);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);

    // R2 raw write, then R11 request during busy
    send(16'h1234, 8'h5A, 1'b0);
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b0, "R11", "ready low while busy", req_ready, 0);
    req_addr = 16'h7777; req_data = 8'h77; req_prog = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    repeat (4) @(negedge clk);
    chk(pulses == 1, "R11", "pulses after ignored request", pulses, 1);

    // R3 program sequence
    send(16'h4000, 8'h3C, 1'b1);
    wait_idle();

    // back-to-back: raw then program held pending during busy
    send(16'hFFFF, 8'hFF, 1'b0);
    send(16'h0000, 8'h00, 1'b1);
    wait_idle();
    repeat (20) @(negedge clk);

    chk(sb_q.size() == 0, "R3", "expected writes left over", sb_q.size(), 0);
    chk(pulses == 10, "R2", "total enable pulses", pulses, 10);
    chk(ce_mis == 0, "R9", "enable mismatch cycles", ce_mis, 0);
    chk(oe_low == 0, "R10", "oe low cycles", oe_low, 0);
    chk(rb_mis == 0, "R10", "busy/ready disagreement cycles", rb_mis, 0);
    finish_run();
  end

endmodule